// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block decides when a small microcontroller core should divert into an interrupt service routine. There are two sources. One is an external pin, which requests service on its falling edge. The other is a one-cycle overflow pulse from a timer. Each source has a pending flag and an enable bit in an 8-bit control register. That register also holds a master enable, and software reads and writes it through a plain register port.

A call can only be granted on a cycle where the core asserts its sample-phase strobe. On such a cycle, a grant also needs three things: the master enable is set, the return stack is not full, and at least one source is both pending and enabled. The external source wins when both qualify.

On a grant, the block pulses a call request for one cycle together with the source's vector address. In the same clock edge it clears the master enable and the flag of the source it served. New events that arrive while service is in progress still set their flags, so they wait for later. A return-with-enable strobe sets the master enable again. A plain return strobe does not. A wake-up output is high whenever any flag is pending.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and call request and wake-up are both low.
- R2: A falling edge on the external pin sets the external flag (bit 4) on the third clock edge after the pin changes. The delay comes from two synchronizer flops plus one edge-detect register. A rising edge sets nothing.
- R3: A one-cycle timer overflow pulse sets the timer flag (bit 5) on the next clock edge.
- R4: A grant produces exactly one cycle of call request, one edge after the deciding cycle. The vector is 0x004 for the external source and 0x008 for the timer. The same edge clears the master enable (bit 0) and the served source's flag.
- R5: When both sources qualify in the same cycle, the external source (enable bit 1) is served first. The timer flag stays pending.
- R6: While the stack-full input is high, no grant is made. A qualifying request is granted on the first sample-phase cycle after stack-full falls.
- R7: Grants are decided only on cycles where the sample-phase strobe is high. A request that is pending while the strobe is low is taken on the next strobe cycle.
- R8: The return-with-enable strobe sets the master enable. The plain return strobe leaves it unchanged.
- R9: An event that arrives while the master enable is clear is recorded in its flag. It is granted once the master enable is set again.
- R10: Software can write and read bits 0, 1, 2 (timer enable), 4 and 5; bits 3, 6 and 7 read 0. If a hardware event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R11: The wake-up output is high exactly when bit 4 or bit 5 is set, whatever the enables hold.
- R12: A pending flag whose source enable is clear is never granted, even with the master enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| stk_full_i | input | 1 | Return stack is full |
| phase_i | input | 1 | Sample-phase strobe; grants happen only while high |
| reti_i | input | 1 | Return-with-enable strobe |
| ret_i | input | 1 | Plain return strobe |
| reg_we_i | input | 1 | Control register write enable |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| call_req_o | output | 1 | One-cycle call request |
| call_vec_o | output | VEC_W | Vector address of the granted source |
| wake_o | output | 1 | Wake-up, high while any flag is pending |

## Verification
The bench drives inputs at the falling clock edge and samples at the falling edge, so every result is read half a cycle after the rising edge that produced it.

Each result has a known delay, and the bench reads it at exactly that edge:

| Stimulus | Result | Due at |
|---|---|---|
| Register write or timer pulse | Value seen on the read port | First rising edge |
| Pin change | External flag | Third rising edge; the bench also confirms it is still clear after the second |
| Cycle where a grant qualifies | Call pulse, and the cleared bits on the read port | Following rising edge |

Before each stimulus that should cause a grant, the bench queues the expected vector. A monitor compares every call pulse against the head of that queue. One cycle later, the main sequence checks that the queue has emptied. That confirms the grant came on its due edge and not later.

// File: rtl/vec_irq_pkg.sv
`timescale 1ns/1ps
package vec_irq_pkg;
   localparam int unsigned REG_W   = 8;
   localparam int unsigned BIT_GEN = 0;
   localparam int unsigned BIT_EEN = 1;
   localparam int unsigned BIT_TEN = 2;
   localparam int unsigned BIT_EFL = 4;
   localparam int unsigned BIT_TFL = 5;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_TMR  = 2'd2
   } src_e;

   typedef struct packed {
      logic gen;
      logic een;
      logic ten;
      logic efl;
      logic tfl;
   } ctl_t;
endpackage

// File: rtl/irq_edge_sync.sv
`timescale 1ns/1ps
module irq_edge_sync #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          FALLING     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic edge_o
);
   localparam logic IDLE_LVL = FALLING;

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   last_q;
   logic                   synced;

   assign synced = chain_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {SYNC_STAGES{IDLE_LVL}};
         last_q  <= IDLE_LVL;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
         last_q  <= synced;
      end
   end

   generate
      if (FALLING) begin : g_fall
         assign edge_o = last_q & ~synced;
      end else begin : g_rise
         assign edge_o = ~last_q & synced;
      end
   endgenerate
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
   import vec_irq_pkg::*;
(
   input  ctl_t ctl_i,
   input  logic phase_i,
   input  logic stk_full_i,
   output logic take_o,
   output src_e src_o
);
   logic ext_rdy;
   logic tmr_rdy;
   logic gate_open;

   assign ext_rdy   = ctl_i.efl & ctl_i.een;
   assign tmr_rdy   = ctl_i.tfl & ctl_i.ten;
   assign gate_open = ctl_i.gen & phase_i & ~stk_full_i;

   always_comb begin
      take_o = 1'b0;
      src_o  = SRC_NONE;
      if (gate_open) begin
         if (ext_rdy) begin
            take_o = 1'b1;
            src_o  = SRC_EXT;
         end else if (tmr_rdy) begin
            take_o = 1'b1;
            src_o  = SRC_TMR;
         end
      end
   end
endmodule

// File: rtl/irq_ctl_reg.sv
`timescale 1ns/1ps
module irq_ctl_reg
   import vec_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             reti_i,
   input  logic             take_i,
   input  src_e             src_i,
   input  logic             ext_evt_i,
   input  logic             tmr_evt_i,
   output ctl_t             ctl_o,
   output logic [REG_W-1:0] rdata_o
);
   ctl_t cur_q;
   ctl_t nxt;
   logic unused_wbits;

   assign unused_wbits = ^{wdata_i[REG_W-1:BIT_TFL+1], wdata_i[BIT_EFL-1:BIT_TEN+1]};

   always_comb begin
      nxt = cur_q;
      if (we_i) begin
         nxt.gen = wdata_i[BIT_GEN];
         nxt.een = wdata_i[BIT_EEN];
         nxt.ten = wdata_i[BIT_TEN];
         nxt.efl = wdata_i[BIT_EFL];
         nxt.tfl = wdata_i[BIT_TFL];
      end
      if (reti_i) nxt.gen = 1'b1;
      if (take_i) begin
         nxt.gen = 1'b0;
         if (src_i == SRC_EXT) nxt.efl = 1'b0;
         if (src_i == SRC_TMR) nxt.tfl = 1'b0;
      end
      if (ext_evt_i) nxt.efl = 1'b1;
      if (tmr_evt_i) nxt.tfl = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= nxt;
   end

   always_comb begin
      rdata_o          = '0;
      rdata_o[BIT_GEN] = cur_q.gen;
      rdata_o[BIT_EEN] = cur_q.een;
      rdata_o[BIT_TEN] = cur_q.ten;
      rdata_o[BIT_EFL] = cur_q.efl;
      rdata_o[BIT_TFL] = cur_q.tfl;
   end

   assign ctl_o = cur_q;
endmodule

// File: rtl/irq_call_out.sv
`timescale 1ns/1ps
module irq_call_out
   import vec_irq_pkg::*;
#(
   parameter int unsigned VEC_W   = 12,
   parameter int unsigned EXT_VEC = 4,
   parameter int unsigned TMR_VEC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  src_e             src_i,
   output logic             call_o,
   output logic [VEC_W-1:0] vec_o
);
   localparam logic [VEC_W-1:0] EXT_V = VEC_W'(EXT_VEC);
   localparam logic [VEC_W-1:0] TMR_V = VEC_W'(TMR_VEC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         call_o <= 1'b0;
         vec_o  <= '0;
      end else begin
         call_o <= take_i;
         if (take_i) vec_o <= (src_i == SRC_EXT) ? EXT_V : TMR_V;
      end
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl
   import vec_irq_pkg::*;
#(
   parameter int unsigned VEC_W       = 12,
   parameter int unsigned EXT_VEC     = 4,
   parameter int unsigned TMR_VEC     = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_pin_i,
   input  logic             tmr_ovf_i,
   input  logic             stk_full_i,
   input  logic             phase_i,
   input  logic             reti_i,
   input  logic             ret_i,
   input  logic             reg_we_i,
   input  logic [7:0]       reg_wdata_i,
   output logic [7:0]       reg_rdata_o,
   output logic             call_req_o,
   output logic [VEC_W-1:0] call_vec_o,
   output logic             wake_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (VEC_W < 4 || VEC_W > 32) begin : g_bad_vw
         $error("VEC_W out of range");
      end
      if (EXT_VEC == TMR_VEC) begin : g_bad_vec
         $error("vectors must differ");
      end
   endgenerate

   ctl_t ctl;
   logic ext_evt;
   logic take;
   src_e src;
   logic unused_ret;

   assign unused_ret = ret_i;

   irq_edge_sync #(.SYNC_STAGES(SYNC_STAGES), .FALLING(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i), .edge_o(ext_evt)
   );

   irq_arbiter u_arb (
      .ctl_i(ctl), .phase_i(phase_i), .stk_full_i(stk_full_i),
      .take_o(take), .src_o(src)
   );

   irq_ctl_reg u_reg (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
      .reti_i(reti_i), .take_i(take), .src_i(src),
      .ext_evt_i(ext_evt), .tmr_evt_i(tmr_ovf_i),
      .ctl_o(ctl), .rdata_o(reg_rdata_o)
   );

   irq_call_out #(.VEC_W(VEC_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)) u_out (
      .clk(clk), .rst_n(rst_n), .take_i(take), .src_i(src),
      .call_o(call_req_o), .vec_o(call_vec_o)
   );

   assign wake_o = ctl.efl | ctl.tfl;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
`timescale 1ns/1ps
module vec_irq_ctrl_chk #(
   parameter int unsigned VEC_W   = 12,
   parameter int unsigned EXT_VEC = 4,
   parameter int unsigned TMR_VEC = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             phase_i,
   input logic             stk_full_i,
   input logic             reti_i,
   input logic             ret_i,
   input logic             reg_we_i,
   input logic [7:0]       reg_rdata_o,
   input logic             call_req_o,
   input logic [VEC_W-1:0] call_vec_o,
   input logic             wake_o
);
   localparam logic [VEC_W-1:0] EXT_V = VEC_W'(EXT_VEC);
   localparam logic [VEC_W-1:0] TMR_V = VEC_W'(TMR_VEC);

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |=> !call_req_o);
   a_r4_gen_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> !reg_rdata_o[0]);
   a_r4_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> (call_vec_o == EXT_V || call_vec_o == TMR_V));
   a_r5_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req_o && $past(reg_rdata_o[4] && reg_rdata_o[1])) |-> call_vec_o == EXT_V);
   a_r6_stack_block: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> !$past(stk_full_i));
   a_r7_phase_only: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> $past(phase_i));
   a_r8_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
      reti_i |=> (reg_rdata_o[0] || call_req_o));
   a_r8_ret_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !reti_i && !reg_we_i && !reg_rdata_o[0]) |=> !reg_rdata_o[0]);
   a_r11_wake_on: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata_o[4] || reg_rdata_o[5]) |-> wake_o);
   a_r11_wake_off: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rdata_o[4] || reg_rdata_o[5]) |-> !wake_o);
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
   .VEC_W(VEC_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .stk_full_i(stk_full_i),
   .reti_i(reti_i), .ret_i(ret_i), .reg_we_i(reg_we_i),
   .reg_rdata_o(reg_rdata_o), .call_req_o(call_req_o),
   .call_vec_o(call_vec_o), .wake_o(wake_o)
);

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
   localparam int unsigned VW = 12;
   localparam logic [VW-1:0] V_EXT = 12'h004;
   localparam logic [VW-1:0] V_TMR = 12'h008;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ext_pin = 1'b1;
   logic          tmr_ovf = 1'b0;
   logic          stk_full = 1'b0;
   logic          phase = 1'b0;
   logic          reti = 1'b0;
   logic          ret = 1'b0;
   logic          we = 1'b0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          call_req;
   logic [VW-1:0] call_vec;
   logic          wake;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [VW-1:0] exp_q [$];

   always #2 clk = ~clk;

   vec_irq_ctrl #(.VEC_W(VW), .EXT_VEC(4), .TMR_VEC(8), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .tmr_ovf_i(tmr_ovf),
      .stk_full_i(stk_full), .phase_i(phase), .reti_i(reti), .ret_i(ret),
      .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .call_req_o(call_req), .call_vec_o(call_vec), .wake_o(wake)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      we = 1'b1; wdata = d;
      tick();
      we = 1'b0;
   endtask

   task automatic expect_call(input logic [VW-1:0] v);
      exp_q.push_back(v);
   endtask

   // monitor: every call pulse is compared with the oldest queued vector (R4)
   always @(negedge clk) begin
      if (rst_n && call_req) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R4 unexpected call actual=0x%0h expected=none", call_vec);
         end else begin
            logic [VW-1:0] e;
            e = exp_q.pop_front();
            if (call_vec != e) begin
               n_bad++;
               $display("FAIL R4 vector actual=0x%0h expected=0x%0h", call_vec, e);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 reg after reset", rdata, 8'h00);
      chk("R1 call after reset", call_req, 0);
      chk("R1 wake after reset", wake, 0);

      // R10 software access, phase low so nothing is granted
      wr(8'hFF);
      chk("R10 readback all ones", rdata, 8'h37);
      chk("R11 wake with flags", wake, 1);
      wr(8'h00);
      chk("R10 readback zero", rdata, 8'h00);
      chk("R11 wake cleared", wake, 0);
      tmr_ovf = 1'b1; we = 1'b1; wdata = 8'h00;
      tick();
      tmr_ovf = 1'b0; we = 1'b0;
      chk("R10 hw set beats sw clear", rdata, 8'h20);
      wr(8'h00);

      // R3 timer flag
      phase = 1'b1;
      tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
      chk("R3 timer flag set", rdata, 8'h20);

      // R12 disabled source never granted
      wr(8'h01);
      tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
      repeat (3) tick();
      chk("R12 disabled flag held", rdata, 8'h21);
      chk("R11 wake ignores enables", wake, 1);

      // R4 timer grant
      expect_call(V_TMR);
      wr(8'h25);
      tick();
      chk("R4 bits cleared on grant", rdata, 8'h04);
      tick();
      chk("R4 call lasts one cycle", call_req, 0);
      chk("R4 timer call issued", exp_q.size(), 0);

      // R9 recorded during service, R8 return strobes
      tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
      repeat (2) tick();
      chk("R9 flag recorded not taken", rdata, 8'h24);
      ret = 1'b1; tick(); ret = 1'b0;
      chk("R8 plain return keeps enable clear", rdata, 8'h24);
      expect_call(V_TMR);
      reti = 1'b1; tick(); reti = 1'b0;
      chk("R8 return-with-enable sets enable", rdata, 8'h25);
      tick();
      chk("R9 taken after re-enable", rdata, 8'h04);
      tick();
      chk("R9 call issued", exp_q.size(), 0);

      // R5 priority
      phase = 1'b0;
      wr(8'h37);
      expect_call(V_EXT);
      expect_call(V_TMR);
      phase = 1'b1;
      tick();
      chk("R5 external served first", rdata, 8'h26);
      tick();
      reti = 1'b1; tick(); reti = 1'b0;
      tick();
      chk("R5 timer served second", rdata, 8'h06);
      tick();
      chk("R5 both calls issued", exp_q.size(), 0);

      // R6 stack full
      stk_full = 1'b1;
      wr(8'h25);
      repeat (3) tick();
      chk("R6 held while stack full", rdata, 8'h25);
      chk("R6 no call while stack full", call_req, 0);
      expect_call(V_TMR);
      stk_full = 1'b0;
      tick();
      chk("R6 taken after stack frees", rdata, 8'h04);
      tick();
      chk("R6 call issued", exp_q.size(), 0);

      // R7 phase strobe
      phase = 1'b0;
      wr(8'h25);
      repeat (3) tick();
      chk("R7 held without phase", rdata, 8'h25);
      expect_call(V_TMR);
      phase = 1'b1;
      tick();
      phase = 1'b0;
      chk("R7 taken on phase cycle", rdata, 8'h04);
      tick();
      chk("R7 call issued", exp_q.size(), 0);

      // R2 external pin path
      wr(8'h03);
      ext_pin = 1'b0;
      repeat (2) tick();
      chk("R2 flag not yet set after two edges", rdata[4], 0);
      tick();
      chk("R2 flag set on third edge", rdata, 8'h13);
      expect_call(V_EXT);
      phase = 1'b1;
      tick();
      chk("R2 external grant clears bits", rdata, 8'h02);
      tick();
      chk("R2 external call issued", exp_q.size(), 0);
      ext_pin = 1'b1;
      repeat (4) tick();
      chk("R2 rising edge sets nothing", rdata, 8'h02);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule